// File: doc/BRIEF.md
# Receive Descriptor Ring Index Controller

This block is the device-side bookkeeping for one receive descriptor ring that lives in host memory. The host programs a configuration word (channel mode, ring size, buffer size, interrupt routing and a buffer-close timeout). It also writes a producer index that marks how far it has handed descriptors to the device. The block keeps the device's own fill index and tells the receive path when a descriptor may be taken. When a buffer completes, the block advances the fill index and presents it for a status write-back. It then raises an interrupt, either at once or after a programmable number of timer units.

Stopping the channel is a handshake. The host writes a mode of off, or pause-at-end-of-frame, and polls an idle flag in a status word until the channel has settled. The block does not move data; it only decides when buffers may be started and which index to report.

Top module: `rx_ring_index_ctrl`

## Requirements
- R1: After reset the configuration reads 0, the fill index is 0, `bufAvail` and `irqPulse` are 0, `statusValid` is 0, and `rxStatusWord` bit 24 (idle) is 1.
- R2: A configuration write keeps only these fields: mode in bits 31:30, ring size code in 23:20, buffer size code in 17:16, interrupt destination in 13:12 and timeout in 11:4. Every other bit reads 0. `bufBytes` equals (buffer size code + 1) * 4096.
- R3: The ring holds 2^k descriptors, where k is the ring size code limited to the range 5..12. The fill index wraps from 2^k-1 to 0.
- R4: Only host index bits below k are used, and bits 2:0 are also ignored, so the producer position is data AND (2^k-1) AND ~7.
- R5: `bufAvail` is 1 only in normal mode (code 10), with no frame in progress, and with the masked fill index different from the producer position. Equal indexes mean no descriptor is free.
- R6: `frameStart` is accepted only while `bufAvail` is 1. `frameDone` counts only while a frame is in progress. Either pulse at any other time changes nothing.
- R7: An accepted `frameDone` makes `statusValid` high for exactly one cycle, starting at the next clock edge. At that point `statusIdx` holds the new fill index (previous + 1, wrapped). `statusIdx` changes at no other time.
- R8: With destination code 01 and timeout 0, `irqPulse` is high in the same cycle as `statusValid`.
- R9: With destination code 01 and timeout T>0, a completion starts a countdown if none is pending. `irqPulse` goes high for one cycle after the T-th `unitTick` that follows. Completions while the countdown is pending do not restart it. Destination codes other than 01 never raise `irqPulse`.
- R10: In pause-at-end-of-frame mode (code 01), a frame in progress may still complete and advance the index. No new frame is accepted, and idle reads 1 once the frame has ended.
- R11: In mode 00 or 11, a frame in progress is dropped without advancing the index. Idle (`rxStatusWord` bit 24) reads 1 once no frame is in progress and the mode is not 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 32 | Configuration write value |
| hostIdxWrEn | input | 1 | Host producer index write strobe |
| hostIdxWrData | input | 12 | Host producer index value |
| unitTick | input | 1 | One pulse per timeout unit |
| frameStart | input | 1 | Receive path takes the next descriptor |
| frameDone | input | 1 | Receive path finished the current buffer |
| cfgRdData | output | 32 | Configuration readback |
| bufBytes | output | 15 | Decoded receive buffer size in bytes |
| bufAvail | output | 1 | A descriptor may be taken now |
| statusValid | output | 1 | One-cycle strobe: write back `statusIdx` |
| statusIdx | output | 12 | Current fill index |
| irqPulse | output | 1 | One-cycle host interrupt |
| rxStatusWord | output | 32 | Status word, bit 24 = channel idle |

## Verification
The hardest state to reach from the ports is the wrap at the top of a large ring together with the full condition. Reaching it means feeding thousands of frames while the producer index is held eight short of the ring end. The bench sweeps every ring size code, including the codes the block clamps. For each code it parks the producer at all-ones so that the low and high bits are discarded, and fills until `bufAvail` drops. It then moves the producer to 0 and fills across the wrap, until the indexes meet again. The pause and off handshakes are reached by changing the mode while a frame is held open between `frameStart` and `frameDone`.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int CFG_W = 32;
  localparam logic [CFG_W-1:0] CFG_KEEP = 32'hC0F3_3FF0;
  localparam int MODE_LO = 30;
  localparam int SIZE_LO = 20;
  localparam int BUF_LO  = 16;
  localparam int DEST_LO = 12;
  localparam int TO_LO   = 4;
  localparam int IDLE_BIT = 24;

  localparam logic [1:0] MODE_NORMAL = 2'b10;
  localparam logic [1:0] MODE_PAUSE  = 2'b01;
  localparam logic [1:0] DEST_HOST   = 2'b01;

  typedef struct packed {
    logic advance;
    logic arm;
    logic fireIrq;
  } ctlStrobes_t;

  typedef struct packed {
    logic modeNormal;
    logic modePause;
    logic room;
    logic irqHost;
    logic toZero;
    logic timerExpire;
  } dpStatus_t;
endpackage

// File: rtl/rx_ring_dp.sv
module rx_ring_dp
  import rx_ring_pkg::*;
#(
  parameter int IDX_W   = 12,
  parameter int MIN_LOG = 5,
  parameter int TO_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              hostIdxWrEn,
  input  logic [IDX_W-1:0]  hostIdxWrData,
  input  logic              unitTick,
  input  ctlStrobes_t       strb,
  output dpStatus_t         stat,
  output logic [CFG_W-1:0]  cfgQ,
  output logic [14:0]       bufBytes,
  output logic              statusValid,
  output logic [IDX_W-1:0]  fillIdx,
  output logic              irqPulse
);
  localparam int MAX_LOG = IDX_W;
  localparam int LOG_W   = $clog2(MAX_LOG + 1);

  logic [IDX_W-1:0] hostIdxQ;
  logic [TO_W-1:0]  timerCnt;
  logic             timerRun;

  logic [3:0]       sizeCode;
  logic [LOG_W-1:0] logSz;
  logic [IDX_W:0]   sizeOne;
  logic [IDX_W:0]   sizeMinus;
  logic [IDX_W-1:0] idxMask;
  logic [IDX_W-1:0] producer;
  logic [TO_W-1:0]  timeoutVal;
  logic [1:0]       modeF;
  logic [2:0]       bufCodeP1;

  assign sizeCode = cfgQ[SIZE_LO +: 4];
  always_comb begin
    if (int'(sizeCode) < MIN_LOG)      logSz = LOG_W'(MIN_LOG);
    else if (int'(sizeCode) > MAX_LOG) logSz = LOG_W'(MAX_LOG);
    else                               logSz = LOG_W'(sizeCode);
  end
  assign sizeOne   = {{IDX_W{1'b0}}, 1'b1} << logSz;
  assign sizeMinus = sizeOne - 1'b1;
  assign idxMask   = sizeMinus[IDX_W-1:0];
  assign producer  = hostIdxQ & idxMask & ~IDX_W'(7);

  assign modeF      = cfgQ[MODE_LO +: 2];
  assign timeoutVal = cfgQ[TO_LO +: TO_W];
  assign bufCodeP1  = {1'b0, cfgQ[BUF_LO +: 2]} + 3'd1;
  assign bufBytes   = {bufCodeP1, 12'b0};

  assign stat.modeNormal  = (modeF == MODE_NORMAL);
  assign stat.modePause   = (modeF == MODE_PAUSE);
  assign stat.room        = ((fillIdx & idxMask) != producer);
  assign stat.irqHost     = (cfgQ[DEST_LO +: 2] == DEST_HOST);
  assign stat.toZero      = (timeoutVal == '0);
  assign stat.timerExpire = timerRun && unitTick && (timerCnt == TO_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ        <= '0;
      hostIdxQ    <= '0;
      fillIdx     <= '0;
      statusValid <= 1'b0;
      irqPulse    <= 1'b0;
      timerCnt    <= '0;
      timerRun    <= 1'b0;
    end else begin
      if (cfgWrEn)     cfgQ     <= cfgWrData & CFG_KEEP;
      if (hostIdxWrEn) hostIdxQ <= hostIdxWrData;
      if (strb.advance) fillIdx <= (fillIdx + 1'b1) & idxMask;
      statusValid <= strb.advance;
      irqPulse    <= strb.fireIrq;
      if (strb.arm && (!timerRun || stat.timerExpire)) begin
        timerCnt <= timeoutVal;
        timerRun <= 1'b1;
      end else if (timerRun && unitTick) begin
        if (timerCnt == TO_W'(1)) timerRun <= 1'b0;
        timerCnt <= timerCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_ring_ctl.sv
module rx_ring_ctl
  import rx_ring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic        frameDone,
  input  dpStatus_t   stat,
  output ctlStrobes_t strb,
  output logic        bufAvail,
  output logic        chanIdle
);
  logic busy;
  logic running;
  logic startOk;
  logic doneOk;

  assign running  = stat.modeNormal || stat.modePause;
  assign bufAvail = stat.modeNormal && stat.room && !busy;
  assign startOk  = bufAvail && frameStart;
  assign doneOk   = busy && frameDone && running;
  assign chanIdle = !busy && !stat.modeNormal;

  assign strb.advance = doneOk;
  assign strb.arm     = doneOk && stat.irqHost && !stat.toZero;
  assign strb.fireIrq = stat.irqHost &&
                        ((doneOk && stat.toZero) || stat.timerExpire);

  always_ff @(posedge clk) begin
    if (!rstN)        busy <= 1'b0;
    else if (!running) busy <= 1'b0;
    else if (doneOk)   busy <= 1'b0;
    else if (startOk)  busy <= 1'b1;
  end
endmodule

// File: rtl/rx_ring_index_ctrl.sv
module rx_ring_index_ctrl
  import rx_ring_pkg::*;
#(
  parameter int IDX_W   = 12,
  parameter int MIN_LOG = 5,
  parameter int TO_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [31:0]       cfgWrData,
  input  logic              hostIdxWrEn,
  input  logic [IDX_W-1:0]  hostIdxWrData,
  input  logic              unitTick,
  input  logic              frameStart,
  input  logic              frameDone,
  output logic [31:0]       cfgRdData,
  output logic [14:0]       bufBytes,
  output logic              bufAvail,
  output logic              statusValid,
  output logic [IDX_W-1:0]  statusIdx,
  output logic              irqPulse,
  output logic [31:0]       rxStatusWord
);
  ctlStrobes_t strb;
  dpStatus_t   stat;
  logic        chanIdle;

  rx_ring_dp #(.IDX_W(IDX_W), .MIN_LOG(MIN_LOG), .TO_W(TO_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .hostIdxWrEn(hostIdxWrEn), .hostIdxWrData(hostIdxWrData),
    .unitTick(unitTick), .strb(strb), .stat(stat),
    .cfgQ(cfgRdData), .bufBytes(bufBytes),
    .statusValid(statusValid), .fillIdx(statusIdx), .irqPulse(irqPulse)
  );

  rx_ring_ctl u_ctl (
    .clk(clk), .rstN(rstN),
    .frameStart(frameStart), .frameDone(frameDone),
    .stat(stat), .strb(strb),
    .bufAvail(bufAvail), .chanIdle(chanIdle)
  );

  assign rxStatusWord = 32'(chanIdle) << IDLE_BIT;
endmodule

// File: rtl/rx_ring_index_ctrl_chk.sv
module rx_ring_index_ctrl_chk #(
  parameter int IDX_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic [31:0]      cfgRdData,
  input logic             bufAvail,
  input logic             statusValid,
  input logic [IDX_W-1:0] statusIdx,
  input logic             irqPulse,
  input logic [31:0]      rxStatusWord
);
  AST_STATUS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |=> !statusValid); // R7

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !statusValid |-> statusIdx == $past(statusIdx)); // R7

  AST_AVAIL_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    bufAvail |-> cfgRdData[31:30] == 2'b10); // R5

  AST_AVAIL_NOT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    bufAvail |-> !rxStatusWord[24]); // R11

  AST_IRQ_DEST: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(cfgRdData[13:12]) == 2'b01); // R9

  AST_IRQ_IMMEDIATE: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && $past(cfgRdData[13:12]) == 2'b01 &&
     $past(cfgRdData[11:4]) == 8'd0) |-> irqPulse); // R8
endmodule

bind rx_ring_index_ctrl rx_ring_index_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgRdData(cfgRdData), .bufAvail(bufAvail),
  .statusValid(statusValid), .statusIdx(statusIdx), .irqPulse(irqPulse),
  .rxStatusWord(rxStatusWord)
);

// File: tb/rx_ring_index_ctrl_tb.sv
module rx_ring_index_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic hostIdxWrEn = 1'b0;
  logic [IDX_W-1:0] hostIdxWrData = '0;
  logic unitTick = 1'b0;
  logic frameStart = 1'b0;
  logic frameDone = 1'b0;
  logic [31:0] cfgRdData;
  logic [14:0] bufBytes;
  logic bufAvail;
  logic statusValid;
  logic [IDX_W-1:0] statusIdx;
  logic irqPulse;
  logic [31:0] rxStatusWord;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_index_ctrl u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .hostIdxWrEn(hostIdxWrEn), .hostIdxWrData(hostIdxWrData),
    .unitTick(unitTick), .frameStart(frameStart), .frameDone(frameDone),
    .cfgRdData(cfgRdData), .bufBytes(bufBytes), .bufAvail(bufAvail),
    .statusValid(statusValid), .statusIdx(statusIdx), .irqPulse(irqPulse),
    .rxStatusWord(rxStatusWord)
  );

  task automatic checkEq(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCfg(input int mode, input int sz,
                                        input int bsz, input int dest, input int to);
    return (32'(mode) << 30) | (32'(sz) << 20) | (32'(bsz) << 16) |
           (32'(dest) << 12) | (32'(to) << 4);
  endfunction

  function automatic int expSize(input int code);
    int k;
    k = (code < 5) ? 5 : ((code > 12) ? 12 : code);
    return 1 << k;
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeCfg(input logic [31:0] v);
    cfgWrData = v; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic writeHost(input int v);
    hostIdxWrData = IDX_W'(v); hostIdxWrEn = 1'b1;
    @(negedge clk);
    hostIdxWrEn = 1'b0;
  endtask

  task automatic startOnly();
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  task automatic doneOnly();
    frameDone = 1'b1;
    @(negedge clk);
    frameDone = 1'b0;
  endtask

  task automatic doFrame();
    startOnly();
    doneOnly();
  endtask

  task automatic tickOnce();
    unitTick = 1'b1;
    @(negedge clk);
    unitTick = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin : stim
    int expIdx;
    int cnt;
    int sz;
    doReset();
    // R1 reset state
    checkEq("R1 cfg", cfgRdData, 0);
    checkEq("R1 idx", statusIdx, 0);
    checkEq("R1 avail", bufAvail, 0);
    checkEq("R1 valid", statusValid, 0);
    checkEq("R1 irq", irqPulse, 0);
    checkEq("R1 idle", rxStatusWord, 32'h0100_0000);

    // R2 field keep mask and buffer size decode
    writeCfg(32'hFFFF_FFFF);
    checkEq("R2 readback", cfgRdData, 32'hC0F3_3FF0);
    for (int b = 0; b < 4; b++) begin
      writeCfg(mkCfg(0, 8, b, 0, 0));
      checkEq("R2 bufBytes", bufBytes, (b + 1) * 4096);
    end

    // R3 R4 R5 R7: sweep every ring size code
    for (int code = 0; code < 16; code++) begin
      doReset();
      sz = expSize(code);
      writeCfg(mkCfg(2, code, 0, 0, 0));
      writeHost(12'hFFF);
      expIdx = 0;
      cnt = 0;
      for (int i = 0; i < 4096; i++) begin
        if (!bufAvail) break;
        doFrame();
        expIdx = (expIdx + 1) % sz;
        cnt++;
        checkEq("R7 valid", statusValid, 1);
        checkEq("R7 idx", statusIdx, expIdx);
      end
      checkEq("R4 fill count", cnt, sz - 8);
      checkEq("R5 full avail", bufAvail, 0);
      writeHost(0);
      for (int i = 0; i < 8; i++) begin
        checkEq("R5 avail", bufAvail, 1);
        doFrame();
        expIdx = (expIdx + 1) % sz;
      end
      checkEq("R3 wrap idx", statusIdx, 0);
      checkEq("R3 full after wrap", bufAvail, 0);
    end

    // R4 low bits ignored
    doReset();
    writeCfg(mkCfg(2, 8, 0, 0, 0));
    writeHost(7);
    checkEq("R4 low bits", bufAvail, 0);
    writeHost(12'h108);
    checkEq("R4 high bits", bufAvail, 1);

    // R6 ignored pulses
    writeHost(0);
    doFrame();
    checkEq("R6 start while full valid", statusValid, 0);
    checkEq("R6 start while full idx", statusIdx, 0);
    writeHost(8);
    doneOnly();
    checkEq("R6 done without start", statusValid, 0);
    checkEq("R6 idx held", statusIdx, 0);

    // R8 immediate interrupt
    writeCfg(mkCfg(2, 8, 0, 1, 0));
    doFrame();
    checkEq("R8 valid", statusValid, 1);
    checkEq("R8 irq", irqPulse, 1);
    @(negedge clk);
    checkEq("R8 irq one cycle", irqPulse, 0);

    // R9 timeout
    writeCfg(mkCfg(2, 8, 0, 1, 3));
    doFrame();
    checkEq("R9 no early irq", irqPulse, 0);
    tickOnce();
    checkEq("R9 tick1", irqPulse, 0);
    tickOnce();
    checkEq("R9 tick2", irqPulse, 0);
    doFrame();
    checkEq("R9 no restart", irqPulse, 0);
    tickOnce();
    checkEq("R9 tick3 irq", irqPulse, 1);
    @(negedge clk);
    checkEq("R9 irq drop", irqPulse, 0);
    writeCfg(mkCfg(2, 8, 0, 0, 0));
    doFrame();
    checkEq("R9 dest none", irqPulse, 0);
    writeCfg(mkCfg(2, 8, 0, 2, 2));
    doFrame();
    for (int t = 0; t < 3; t++) begin
      tickOnce();
      checkEq("R9 dest 10 silent", irqPulse, 0);
    end

    // R10 pause at end of frame
    doReset();
    writeCfg(mkCfg(2, 8, 0, 0, 0));
    writeHost(16);
    startOnly();
    writeCfg(mkCfg(1, 8, 0, 0, 0));
    checkEq("R10 busy not idle", rxStatusWord[24], 0);
    checkEq("R10 no avail", bufAvail, 0);
    doneOnly();
    checkEq("R10 completes", statusValid, 1);
    checkEq("R10 idx", statusIdx, 1);
    checkEq("R10 idle", rxStatusWord[24], 1);
    doFrame();
    checkEq("R10 no new frame", statusValid, 0);
    checkEq("R10 idx held", statusIdx, 1);

    // R11 off and mode 11
    writeCfg(mkCfg(2, 8, 0, 0, 0));
    checkEq("R11 running not idle", rxStatusWord[24], 0);
    startOnly();
    writeCfg(0);
    checkEq("R11 cfg zero", cfgRdData, 0);
    @(negedge clk);
    checkEq("R11 idle", rxStatusWord, 32'h0100_0000);
    doneOnly();
    checkEq("R11 dropped", statusValid, 0);
    checkEq("R11 idx held", statusIdx, 1);
    writeCfg(mkCfg(2, 8, 0, 0, 0));
    startOnly();
    writeCfg(mkCfg(3, 8, 0, 0, 0));
    @(negedge clk);
    checkEq("R11 mode11 idle", rxStatusWord[24], 1);
    doneOnly();
    checkEq("R11 mode11 dropped", statusIdx, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule